// File: doc/BRIEF.md
# PAM4 Symbol Error Analyzer

This block sits behind the slicer of a PAM4 receive path. Each cycle in which `in_valid` is high it takes one received two-bit symbol and the matching bits from a local reference generator. It passes the reference through the same optional Gray mapping, precoder and per-bit inversion that the transmitter applies, then compares the result with the received symbol.

The comparison results go into a bank of saturating counters:

- compared symbols,
- symbol errors,
- bit errors,
- MSB-lane errors,
- LSB-lane errors,
- one error counter for each of the four expected levels.

When the link cannot be aligned on whole symbols, a diagnostic mode compares each lane with the raw reference bits. In that mode only the lane counters advance.

A small state machine follows runs of errored symbols. It raises a sticky flag when a run grows longer than a programmable limit, and it keeps the longest run seen. A clear strobe zeroes all statistics in one cycle. A snapshot strobe copies every counter into readout registers in one cycle.

The burst tracker has three states:

- `BST_CLEAN`: no run in progress.
- `BST_RUN`: errored run, not longer than the limit.
- `BST_BURST`: errored run, longer than the limit.

Its transitions:

- An errored symbol moves `BST_CLEAN` to `BST_RUN`, or straight to `BST_BURST` when a run length of one already exceeds the limit.
- An errored symbol keeps `BST_RUN` in place, or moves it to `BST_BURST` once the run length exceeds the limit.
- An errored symbol keeps `BST_BURST` in place.
- A clean symbol moves `BST_RUN` or `BST_BURST` back to `BST_CLEAN`.
- A clear forces `BST_CLEAN` from any state.
- Cycles without `in_valid` change nothing.

Top module: `pam4_ser_analyzer`

## Requirements
- R1: Every cycle with `in_valid` high and `clr` low adds one to the compared-symbol counter, in both modes.
- R2: The expected level is derived from the reference bits d in three steps, in this order.
  - Gray step: when `gray_en` is high, the level is {d[1], d[1]^d[0]}; otherwise it is d unchanged.
  - Precoder step: when `precode_en` is high, the Gray-step result g is replaced by (g − p) mod 4. Here p is the previous precoder output. The precoder state updates on every valid symbol, whatever the mode or enables, and only reset clears it.
  - Inversion step: bit 1 of the result is XORed with `inv_msb` and bit 0 with `inv_lsb`.
- R3: In normal mode (`diag_mode`=0), a symbol error is counted whenever either bit differs from the expected level. The bit-error counter grows by the number of differing bits (1 or 2). The MSB counter grows when bit 1 differs and the LSB counter when bit 0 differs.
- R4: In normal mode, an errored symbol also increments the level counter selected by the binary value of its expected level. Level k occupies `snap_lvl_err[k*CW +: CW]`.
- R5: In diagnostic mode, each lane of `rx_sym` is compared with the raw reference bits XOR the inversion settings. Only the MSB and LSB counters advance. The symbol, bit and level counters stay unchanged.
- R6: Every counter saturates at 2^CW−1.
- R7: A `clr` pulse zeroes every counter, the burst flag and the longest-run value. A symbol presented in the same cycle is not counted.
- R8: A `snap` pulse copies all counters together, taking the values they held before that edge. A symbol in the same cycle is therefore excluded. With `clr` in the same cycle, the pre-clear values are captured.
- R9: `burst_flag` rises on the edge that takes the run of consecutive errored symbols above `burst_limit`. Cycles without `in_valid` neither extend nor break a run. The flag stays set until `clr`.
- R10: `max_run` holds the longest run of errored symbols since the last clear, saturating at 2^RLW−1.
- R11: After reset, all counters, snapshots, `burst_flag` and `max_run` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Clear all statistics |
| snap | input | 1 | Latch all counters into snapshot registers |
| in_valid | input | 1 | A symbol is present this cycle |
| rx_sym | input | 2 | Received symbol, bit 1 = MSB |
| ref_bits | input | 2 | Reference data bits before coding |
| diag_mode | input | 1 | 1 = compare lanes independently |
| inv_msb | input | 1 | Invert the MSB of the expected symbol |
| inv_lsb | input | 1 | Invert the LSB of the expected symbol |
| gray_en | input | 1 | Enable Gray mapping |
| precode_en | input | 1 | Enable precoder |
| burst_limit | input | RLW | Longest run length allowed without a burst |
| snap_symbols | output | CW | Snapshot of compared symbols |
| snap_sym_err | output | CW | Snapshot of symbol errors |
| snap_bit_err | output | CW | Snapshot of bit errors |
| snap_msb_err | output | CW | Snapshot of MSB-lane errors |
| snap_lsb_err | output | CW | Snapshot of LSB-lane errors |
| snap_lvl_err | output | 4*CW | Snapshot of per-level symbol errors |
| burst_flag | output | 1 | Sticky burst indication |
| max_run | output | RLW | Longest errored run since clear |

## Verification
Clear and snapshot can land on the same edge, and an errored symbol can arrive with them. The bench drives an errored symbol together with `clr` and `snap` in one cycle. It then expects the snapshot to hold the totals from before that edge and the counters, burst flag and longest run to be zero. A second snapshot right after must read all zeros, which shows the simultaneous symbol was dropped rather than counted after the clear.

// File: rtl/pam4_ana_pkg.sv
package pam4_ana_pkg;

    typedef enum logic [1:0] {
        BST_CLEAN = 2'd0,
        BST_RUN   = 2'd1,
        BST_BURST = 2'd2
    } bst_state_t;

    localparam int NUM_LVL  = 4;
    localparam int CI_SYM   = 0;
    localparam int CI_SERR  = 1;
    localparam int CI_BERR  = 2;
    localparam int CI_MERR  = 3;
    localparam int CI_LERR  = 4;
    localparam int CI_LVL0  = 5;
    localparam int NUM_CNT  = CI_LVL0 + NUM_LVL;

    // Gray map: 00->0, 01->1, 11->2, 10->3
    function automatic logic [1:0] gray_to_level(input logic [1:0] d);
        return {d[1], d[1] ^ d[0]};
    endfunction

endpackage

// File: rtl/pam4_ref_coder.sv
module pam4_ref_coder
    import pam4_ana_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [1:0] ref_bits,
    input  logic       gray_en,
    input  logic       precode_en,
    input  logic       inv_msb,
    input  logic       inv_lsb,
    output logic [1:0] exp_level,
    output logic [1:0] exp_lanes
);

    logic [1:0] prev_q;
    logic [1:0] gray_lvl;
    logic [1:0] pre_lvl;
    logic [1:0] coded;

    always_comb begin
        gray_lvl  = gray_en ? gray_to_level(ref_bits) : ref_bits;
        pre_lvl   = gray_lvl - prev_q;
        coded     = precode_en ? pre_lvl : gray_lvl;
        exp_level = coded ^ {inv_msb, inv_lsb};
        exp_lanes = ref_bits ^ {inv_msb, inv_lsb};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            prev_q <= 2'd0;
        else if (in_valid)
            prev_q <= pre_lvl;
    end

    // R2
    prec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> prev_q == $past(prev_q));

endmodule

// File: rtl/pam4_sat_counter.sv
module pam4_sat_counter #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [1:0]    inc,
    output logic [CW-1:0] cnt
);

    localparam logic [CW-1:0] MAXV = '1;

    logic [CW:0]   sum;
    logic [CW-1:0] nxt;

    always_comb begin
        sum = {1'b0, cnt} + {{(CW-1){1'b0}}, inc};
        nxt = sum[CW] ? MAXV : sum[CW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else
            cnt <= nxt;
    end

    // R7
    cnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == '0);

    // R6
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAXV && !clr) |=> cnt == MAXV);

    // R6
    cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> cnt >= $past(cnt));

endmodule

// File: rtl/pam4_burst_fsm.sv
module pam4_burst_fsm
    import pam4_ana_pkg::*;
#(
    parameter int RLW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           sym_valid,
    input  logic           sym_errored,
    input  logic [RLW-1:0] limit,
    output logic           burst_flag,
    output logic [RLW-1:0] max_run
);

    localparam logic [RLW-1:0] RUN_MAX = '1;
    localparam logic [RLW-1:0] RUN_ONE = RLW'(1);

    bst_state_t     state_q, state_d;
    logic [RLW-1:0] run_q, run_d, run_inc;

    assign run_inc = (run_q == RUN_MAX) ? RUN_MAX : run_q + RUN_ONE;

    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        if (sym_valid) begin
            unique case (state_q)
                BST_CLEAN: begin
                    if (sym_errored) begin
                        run_d   = RUN_ONE;
                        state_d = (RUN_ONE > limit) ? BST_BURST : BST_RUN;
                    end
                end
                BST_RUN: begin
                    if (sym_errored) begin
                        run_d   = run_inc;
                        state_d = (run_inc > limit) ? BST_BURST : BST_RUN;
                    end else begin
                        run_d   = '0;
                        state_d = BST_CLEAN;
                    end
                end
                BST_BURST: begin
                    if (sym_errored) begin
                        run_d = run_inc;
                    end else begin
                        run_d   = '0;
                        state_d = BST_CLEAN;
                    end
                end
                default: begin
                    run_d   = '0;
                    state_d = BST_CLEAN;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= BST_CLEAN;
        else if (clr)
            state_q <= BST_CLEAN;
        else
            state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q      <= '0;
            burst_flag <= 1'b0;
            max_run    <= '0;
        end else if (clr) begin
            run_q      <= '0;
            burst_flag <= 1'b0;
            max_run    <= '0;
        end else begin
            run_q <= run_d;
            if (state_d == BST_BURST)
                burst_flag <= 1'b1;
            if (run_d > max_run)
                max_run <= run_d;
        end
    end

    // R9
    burst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_flag && !clr) |=> burst_flag);

    // R9
    burst_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == BST_BURST |-> burst_flag);

    // R10
    max_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        max_run >= run_q);

    // R9
    run_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sym_valid && !clr) |=> run_q == $past(run_q));

endmodule

// File: rtl/pam4_ser_analyzer.sv
module pam4_ser_analyzer
    import pam4_ana_pkg::*;
#(
    parameter int CW  = 32,
    parameter int RLW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              snap,
    input  logic              in_valid,
    input  logic [1:0]        rx_sym,
    input  logic [1:0]        ref_bits,
    input  logic              diag_mode,
    input  logic              inv_msb,
    input  logic              inv_lsb,
    input  logic              gray_en,
    input  logic              precode_en,
    input  logic [RLW-1:0]    burst_limit,
    output logic [CW-1:0]     snap_symbols,
    output logic [CW-1:0]     snap_sym_err,
    output logic [CW-1:0]     snap_bit_err,
    output logic [CW-1:0]     snap_msb_err,
    output logic [CW-1:0]     snap_lsb_err,
    output logic [4*CW-1:0]   snap_lvl_err,
    output logic              burst_flag,
    output logic [RLW-1:0]    max_run
);

    logic [1:0]    exp_level, exp_lanes, diff;
    logic          normal, sym_bad;
    logic [1:0]    inc_arr  [NUM_CNT];
    logic [CW-1:0] cnt_arr  [NUM_CNT];
    logic [CW-1:0] snap_arr [NUM_CNT];

    pam4_ref_coder u_coder (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .ref_bits   (ref_bits),
        .gray_en    (gray_en),
        .precode_en (precode_en),
        .inv_msb    (inv_msb),
        .inv_lsb    (inv_lsb),
        .exp_level  (exp_level),
        .exp_lanes  (exp_lanes)
    );

    always_comb begin
        diff    = (diag_mode ? exp_lanes : exp_level) ^ rx_sym;
        normal  = in_valid && !diag_mode;
        sym_bad = |diff;
        inc_arr[CI_SYM]  = {1'b0, in_valid};
        inc_arr[CI_SERR] = {1'b0, normal && sym_bad};
        inc_arr[CI_BERR] = normal ? ({1'b0, diff[1]} + {1'b0, diff[0]}) : 2'd0;
        inc_arr[CI_MERR] = {1'b0, in_valid && diff[1]};
        inc_arr[CI_LERR] = {1'b0, in_valid && diff[0]};
        for (int k = 0; k < NUM_LVL; k++)
            inc_arr[CI_LVL0+k] = {1'b0, normal && sym_bad && (exp_level == 2'(k))};
    end

    for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
        pam4_sat_counter #(.CW(CW)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .inc   (inc_arr[gi]),
            .cnt   (cnt_arr[gi])
        );
    end

    pam4_burst_fsm #(.RLW(RLW)) u_burst (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (clr),
        .sym_valid   (in_valid),
        .sym_errored (sym_bad),
        .limit       (burst_limit),
        .burst_flag  (burst_flag),
        .max_run     (max_run)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CNT; i++) snap_arr[i] <= '0;
        end else if (snap) begin
            for (int i = 0; i < NUM_CNT; i++) snap_arr[i] <= cnt_arr[i];
        end
    end

    assign snap_symbols = snap_arr[CI_SYM];
    assign snap_sym_err = snap_arr[CI_SERR];
    assign snap_bit_err = snap_arr[CI_BERR];
    assign snap_msb_err = snap_arr[CI_MERR];
    assign snap_lsb_err = snap_arr[CI_LERR];
    for (genvar lk = 0; lk < NUM_LVL; lk++) begin : g_lvl_out
        assign snap_lvl_err[lk*CW +: CW] = snap_arr[CI_LVL0+lk];
    end

    // R5
    diag_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (diag_mode && !clr) |=> cnt_arr[CI_SERR] == $past(cnt_arr[CI_SERR]));

    // R3
    bits_ge_syms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_arr[CI_BERR] >= cnt_arr[CI_SERR]);

    // R8
    snap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> snap_symbols == $past(cnt_arr[CI_SYM]));

    // R8
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !snap |=> $stable(snap_sym_err));

endmodule

// File: tb/sim_pam4_ser_analyzer.sv
`timescale 1ns/1ps
module sim_pam4_ser_analyzer;

    localparam int CW   = 6;
    localparam int RLW  = 4;
    localparam int MAXC = (1 << CW) - 1;
    localparam int MAXR = (1 << RLW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0, snap = 1'b0, in_valid = 1'b0;
    logic [1:0] rx_sym = 2'd0, ref_bits = 2'd0;
    logic diag_mode = 1'b0, inv_msb = 1'b0, inv_lsb = 1'b0;
    logic gray_en = 1'b0, precode_en = 1'b0;
    logic [RLW-1:0] burst_limit = '1;
    logic [CW-1:0] snap_symbols, snap_sym_err, snap_bit_err, snap_msb_err, snap_lsb_err;
    logic [4*CW-1:0] snap_lvl_err;
    logic burst_flag;
    logic [RLW-1:0] max_run;

    always #2.5 clk = ~clk;

    pam4_ser_analyzer #(.CW(CW), .RLW(RLW)) u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .snap(snap), .in_valid(in_valid),
        .rx_sym(rx_sym), .ref_bits(ref_bits), .diag_mode(diag_mode),
        .inv_msb(inv_msb), .inv_lsb(inv_lsb), .gray_en(gray_en),
        .precode_en(precode_en), .burst_limit(burst_limit),
        .snap_symbols(snap_symbols), .snap_sym_err(snap_sym_err),
        .snap_bit_err(snap_bit_err), .snap_msb_err(snap_msb_err),
        .snap_lsb_err(snap_lsb_err), .snap_lvl_err(snap_lvl_err),
        .burst_flag(burst_flag), .max_run(max_run)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    int m_cnt [9];
    int m_snap [9];
    int p_prev = 0, run = 0, mx = 0;
    bit flag = 1'b0;
    string tag_of [9] = '{"R1", "R3", "R3", "R3", "R3", "R4", "R4", "R4", "R4"};

    task automatic chk(string tag, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic int sat(int v);
        return (v > MAXC) ? MAXC : v;
    endfunction

    function automatic logic [1:0] pre_of(logic [1:0] d);
        logic [1:0] g;
        g = gray_en ? {d[1], d[1] ^ d[0]} : d;
        return 2'(g - 2'(p_prev));
    endfunction

    function automatic logic [1:0] exp_of(logic [1:0] d);
        logic [1:0] g;
        logic [1:0] l;
        g = gray_en ? {d[1], d[1] ^ d[0]} : d;
        l = precode_en ? pre_of(d) : g;
        return l ^ {inv_msb, inv_lsb};
    endfunction

    function automatic int snap_val(int i);
        case (i)
            0: return int'(snap_symbols);
            1: return int'(snap_sym_err);
            2: return int'(snap_bit_err);
            3: return int'(snap_msb_err);
            4: return int'(snap_lsb_err);
            default: return int'(snap_lvl_err[(i-5)*CW +: CW]);
        endcase
    endfunction

    task automatic step(bit v, logic [1:0] rx, logic [1:0] d, bit c, bit s);
        logic [1:0] e, el, df, pc;
        @(negedge clk);
        in_valid = v; rx_sym = rx; ref_bits = d; clr = c; snap = s;
        e  = exp_of(d);
        el = d ^ {inv_msb, inv_lsb};
        pc = pre_of(d);
        @(posedge clk);
        #1;
        in_valid = 1'b0; clr = 1'b0; snap = 1'b0;
        if (v) p_prev = int'(pc);
        if (s) for (int i = 0; i < 9; i++) m_snap[i] = m_cnt[i];
        if (c) begin
            for (int i = 0; i < 9; i++) m_cnt[i] = 0;
            run = 0; mx = 0; flag = 1'b0;
        end else if (v) begin
            df = diag_mode ? (el ^ rx) : (e ^ rx);
            m_cnt[0] = sat(m_cnt[0] + 1);
            if (!diag_mode) begin
                if (df != 2'd0) begin
                    m_cnt[1] = sat(m_cnt[1] + 1);
                    m_cnt[5 + int'(e)] = sat(m_cnt[5 + int'(e)] + 1);
                end
                m_cnt[2] = sat(m_cnt[2] + int'(df[1]) + int'(df[0]));
            end
            m_cnt[3] = sat(m_cnt[3] + int'(df[1]));
            m_cnt[4] = sat(m_cnt[4] + int'(df[0]));
            if (df != 2'd0) begin
                run = (run + 1 > MAXR) ? MAXR : run + 1;
                if (run > int'(burst_limit)) flag = 1'b1;
                if (run > mx) mx = run;
            end else begin
                run = 0;
            end
        end
        chk("R9 burst_flag", int'(burst_flag), int'(flag));
        chk("R10 max_run", int'(max_run), mx);
        if (s) for (int i = 0; i < 9; i++) chk(tag_of[i], snap_val(i), m_snap[i]);
    endtask

    task automatic sym(logic [1:0] d, logic [1:0] err);
        step(1'b1, exp_of(d) ^ err, d, 1'b0, 1'b0);
    endtask

    task automatic take_snap();
        step(1'b0, 2'd0, 2'd0, 1'b0, 1'b1);
    endtask

    initial begin
        for (int i = 0; i < 9; i++) begin m_cnt[i] = 0; m_snap[i] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R11 reset state
        chk("R11 flag", int'(burst_flag), 0);
        chk("R11 max_run", int'(max_run), 0);
        chk("R11 snap_symbols", int'(snap_symbols), 0);
        take_snap();

        // R2/R3/R4: sweep all coding settings, data values and error patterns
        burst_limit = 4'd15;
        for (int cfg = 0; cfg < 16; cfg++) begin
            @(negedge clk);
            gray_en = cfg[3]; precode_en = cfg[2]; inv_msb = cfg[1]; inv_lsb = cfg[0];
            step(1'b0, 2'd0, 2'd0, 1'b1, 1'b0);
            for (int k = 0; k < 8; k++) sym(2'(k), 2'd0);
            take_snap();
            chk("R2 clean stream gives no symbol errors", int'(snap_sym_err), 0);
            for (int d = 0; d < 4; d++)
                for (int er = 0; er < 4; er++) sym(2'(d), 2'(er));
            take_snap();
        end

        // R5: diagnostic lanes, coding enables must not matter
        @(negedge clk);
        diag_mode = 1'b1; gray_en = 1'b1; precode_en = 1'b1;
        for (int cfg = 0; cfg < 4; cfg++) begin
            @(negedge clk);
            inv_msb = cfg[1]; inv_lsb = cfg[0];
            step(1'b0, 2'd0, 2'd0, 1'b1, 1'b0);
            for (int d = 0; d < 4; d++)
                for (int er = 0; er < 4; er++)
                    step(1'b1, 2'(d) ^ {inv_msb, inv_lsb} ^ 2'(er), 2'(d), 1'b0, 1'b0);
            take_snap();
            chk("R5 symbol errors frozen", int'(snap_sym_err), 0);
            chk("R5 msb lane errors", int'(snap_msb_err), 8);
        end
        @(negedge clk);
        diag_mode = 1'b0; gray_en = 1'b0; precode_en = 1'b0; inv_msb = 1'b0; inv_lsb = 1'b0;

        // R7/R8: clear, snapshot and an errored symbol in one cycle
        step(1'b0, 2'd0, 2'd0, 1'b1, 1'b0);
        sym(2'd1, 2'd3); sym(2'd2, 2'd1); sym(2'd0, 2'd0);
        step(1'b1, 2'd3, 2'd0, 1'b1, 1'b1);
        chk("R8 snapshot before clear", int'(snap_sym_err), 2);
        chk("R7 flag cleared", int'(burst_flag), 0);
        take_snap();
        chk("R7 symbol under clear not counted", int'(snap_symbols), 0);

        // R6: saturation
        for (int k = 0; k < 70; k++) sym(2'(k), 2'd3);
        take_snap();
        chk("R6 bit errors saturate", int'(snap_bit_err), MAXC);
        chk("R6 symbol errors saturate", int'(snap_sym_err), MAXC);

        // R9/R10: burst detection
        @(negedge clk);
        burst_limit = 4'd3;
        step(1'b0, 2'd0, 2'd0, 1'b1, 1'b0);
        for (int k = 0; k < 3; k++) sym(2'(k), 2'd1);
        sym(2'd0, 2'd0);
        chk("R9 run equal to limit no flag", int'(burst_flag), 0);
        sym(2'd1, 2'd2); sym(2'd2, 2'd2);
        step(1'b0, 2'd0, 2'd0, 1'b0, 1'b0);
        step(1'b0, 2'd0, 2'd0, 1'b0, 1'b0);
        sym(2'd3, 2'd1);
        chk("R9 gap does not break run", int'(burst_flag), 0);
        sym(2'd0, 2'd1);
        chk("R9 run above limit flags", int'(burst_flag), 1);
        for (int k = 0; k < 5; k++) sym(2'(k), 2'd0);
        chk("R9 flag sticky", int'(burst_flag), 1);
        chk("R10 longest run", int'(max_run), 4);
        for (int k = 0; k < 20; k++) sym(2'(k), 2'd3);
        chk("R10 run saturates", int'(max_run), MAXR);
        step(1'b0, 2'd0, 2'd0, 1'b1, 1'b0);
        @(negedge clk);
        burst_limit = 4'd0;
        sym(2'd2, 2'd0);
        chk("R9 clean symbol limit zero", int'(burst_flag), 0);
        sym(2'd2, 2'd2);
        chk("R9 single error over limit zero", int'(burst_flag), 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule